// File: doc/BRIEF.md
# Selectable Binary-Field Polynomial Reducer

This block takes the unreduced product of a binary-field multiply and returns its remainder modulo the field polynomial. It supports five field sizes: degrees 163, 233, 283, 409 and 571. Each size has its own fixed XOR network, and every network works on the same input in parallel. A three-bit select code then chooses which network's result reaches the output.

The block is purely combinational. It has no clock, no state and no handshake, so the output follows the inputs within the same cycle. A surrounding datapath feeds it the carry-less product, zero-extended to the widest width. The datapath then takes back the remainder, zero-padded to 571 bits. Each network folds the high half of the product onto the low half twice, which brings the result below degree m.

Top module: `gf2_multi_reducer`

## Requirements
- R1: With select code 0, the output is the input reduced modulo x^163 + x^7 + x^6 + x^3 + 1.
- R2: With select code 1, the output is the input reduced modulo x^233 + x^74 + 1.
- R3: With select code 2, the output is the input reduced modulo x^283 + x^12 + x^7 + x^5 + 1.
- R4: With select code 3, the output is the input reduced modulo x^409 + x^87 + 1.
- R5: With select code 4, the output is the input reduced modulo x^571 + x^10 + x^5 + x^2 + 1.
- R6: Select codes 5, 6 and 7 give an all-zero output, whatever the product input holds.
- R7: For a valid select code with field degree m, every output bit at position m or above is zero.
- R8: When the input has no bit set at position m or above, the output equals the input's low bits unchanged.
- R9: The output settles to the result for the present select code and product without any clock edge, so a change of select alone changes the output in the same cycle.

The product input is read only up to bit 2m-2 of the selected field. A caller must keep the bits above that position at zero, because a correct result is defined only for such inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| field_sel | input | 3 | Field select code: 0=163, 1=233, 2=283, 3=409, 4=571, 5..7 invalid |
| prod | input | 1141 | Unreduced product, bit i is the coefficient of x^i |
| rem | output | 571 | Reduced element, zero above the selected degree |

## Verification
The bound checker evaluates the following whenever an input changes:
- the all-zero output for invalid codes;
- the degree bound on the output;
- the pass-through of inputs that are already reduced;
- the exact image of the single term x^m for each field.

Full reduction correctness for arbitrary products can only be shown by the bench's scenarios. The bench compares random and directed products against a bit-serial long division that it computes itself. The same-cycle response to a change of select alone is also a bench scenario.

// File: rtl/gf2red_pkg.sv
package gf2red_pkg;
  localparam int NFLD = 5;
  localparam int MAXM = 571;
  localparam int PW   = 2 * MAXM - 1;
  localparam int SELW = 3;

  // field degree and the three lower tap positions (0 means trinomial)
  localparam int FLD_M  [NFLD] = '{163, 233, 283, 409, 571};
  localparam int FLD_KA [NFLD] = '{7, 74, 12, 87, 10};
  localparam int FLD_KB [NFLD] = '{6, 0, 7, 0, 5};
  localparam int FLD_KC [NFLD] = '{3, 0, 5, 0, 2};

  function automatic int fld_deg(input logic [SELW-1:0] s);
    fld_deg = 0;
    for (int i = 0; i < NFLD; i++)
      if (s == SELW'(i)) fld_deg = FLD_M[i];
  endfunction

  // low part of the modulus, i.e. the remainder of x^m
  function automatic logic [MAXM-1:0] tap_image(input logic [SELW-1:0] s);
    tap_image = '0;
    for (int i = 0; i < NFLD; i++)
      if (s == SELW'(i)) begin
        tap_image[0] = 1'b1;
        tap_image[FLD_KA[i]] = 1'b1;
        if (FLD_KB[i] != 0) begin
          tap_image[FLD_KB[i]] = 1'b1;
          tap_image[FLD_KC[i]] = 1'b1;
        end
      end
  endfunction
endpackage

// File: rtl/gf2_fold.sv
module gf2_fold #(
  parameter int M     = 163,
  parameter int KA    = 7,
  parameter int KB    = 6,
  parameter int KC    = 3,
  parameter bit PENTA = 1'b1,
  parameter int PW    = 1141,
  parameter int OW    = 571
) (
  input  logic [PW-1:0] prod,
  output logic [OW-1:0] red
);
  localparam int W  = 2 * M - 1;  // meaningful product width
  localparam int FW = M + KA;     // width after the first fold

  logic [M-2:0]  hi1;
  logic [FW-1:0] lo1, h1x, f1;
  logic [KA-1:0] hi2;
  logic [M-1:0]  lo2, h2x, f2;

  assign hi1 = prod[W-1:M];
  assign lo1 = FW'(prod[M-1:0]);
  assign h1x = FW'(hi1);
  assign hi2 = f1[FW-1:M];
  assign lo2 = f1[M-1:0];
  assign h2x = M'(hi2);

  generate
    if (PENTA) begin : g_five
      assign f1 = lo1 ^ h1x ^ (h1x << KA) ^ (h1x << KB) ^ (h1x << KC);
      assign f2 = lo2 ^ h2x ^ (h2x << KA) ^ (h2x << KB) ^ (h2x << KC);
    end else begin : g_three
      assign f1 = lo1 ^ h1x ^ (h1x << KA);
      assign f2 = lo2 ^ h2x ^ (h2x << KA);
    end
  endgenerate

  assign red = OW'(f2);
endmodule

// File: rtl/gf2_sel_mux.sv
module gf2_sel_mux #(
  parameter int NF   = 5,
  parameter int OW   = 571,
  parameter int SELW = 3
) (
  input  logic [SELW-1:0] sel,
  input  logic [OW-1:0]   cand [NF],
  output logic [OW-1:0]   res
);
  always_comb begin
    res = '0;
    for (int i = 0; i < NF; i++)
      if (sel == SELW'(i)) res = cand[i];
  end
endmodule

// File: rtl/gf2_multi_reducer.sv
module gf2_multi_reducer
  import gf2red_pkg::*;
(
  input  logic [SELW-1:0] field_sel,
  input  logic [PW-1:0]   prod,
  output logic [MAXM-1:0] rem
);
  logic [MAXM-1:0] cand [NFLD];

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    gf2_fold #(
      .M(FLD_M[g]), .KA(FLD_KA[g]), .KB(FLD_KB[g]), .KC(FLD_KC[g]),
      .PENTA(FLD_KB[g] != 0), .PW(PW), .OW(MAXM)
    ) u_fold (
      .prod(prod),
      .red (cand[g])
    );
  end

  gf2_sel_mux #(.NF(NFLD), .OW(MAXM), .SELW(SELW)) u_mux (
    .sel (field_sel),
    .cand(cand),
    .res (rem)
  );
endmodule

// File: rtl/gf2_multi_reducer_chk.sv
module gf2_multi_reducer_chk
  import gf2red_pkg::*;
(
  input logic [SELW-1:0] field_sel,
  input logic [PW-1:0]   prod,
  input logic [MAXM-1:0] rem
);
  int unsigned m;

  always_comb begin
    m = fld_deg(field_sel);
    if (m == 0) begin
      assert_invalid_zero_R6: assert (rem == '0) else $error("invalid code gave nonzero");
    end else begin
      assert_deg_bound_R7: assert ((rem >> m) == '0) else $error("bits above degree");
      if ((prod >> m) == '0) begin
        assert_passthru_R8: assert (rem == prod[MAXM-1:0]) else $error("reduced input altered");
      end
      // covers R1 R2 R3 R4 R5: x^m must map to the modulus low terms
      if (prod == (PW'(1) << m)) begin
        assert_xm_image_R1: assert (rem == tap_image(field_sel)) else $error("x^m image wrong");
      end
    end
  end
endmodule

bind gf2_multi_reducer gf2_multi_reducer_chk u_chk (
  .field_sel(field_sel),
  .prod     (prod),
  .rem      (rem)
);

// File: tb/gf2_multi_reducer_test.sv
module gf2_multi_reducer_test;
  localparam int PWT = 1141;
  localparam int OWT = 571;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]     sel;
  logic [PWT-1:0] p;
  logic [OWT-1:0] r;
  int n_run = 0, n_fail = 0, cyc = 0;

  int    deg [5] = '{163, 233, 283, 409, 571};
  int    ta  [5] = '{7, 74, 12, 87, 10};
  int    tb_ [5] = '{6, 0, 7, 0, 5};
  int    tc  [5] = '{3, 0, 5, 0, 2};
  string ftag[5] = '{"R1", "R2", "R3", "R4", "R5"};

  always #2.5 clk = ~clk;

  gf2_multi_reducer uut (.field_sel(sel), .prod(p), .rem(r));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // bit-serial long division, independent of the fold structure
  function automatic logic [OWT-1:0] ref_red(input logic [PWT-1:0] c, input int s);
    logic [PWT-1:0] v;
    logic [OWT-1:0] o;
    int m;
    o = '0;
    if (s > 4) return o;
    v = c; m = deg[s];
    for (int i = PWT - 1; i >= m; i--)
      if (v[i]) begin
        v[i] = 1'b0;
        v[i-m] ^= 1'b1;
        v[i-m+ta[s]] ^= 1'b1;
        if (tb_[s] != 0) begin
          v[i-m+tb_[s]] ^= 1'b1;
          v[i-m+tc[s]] ^= 1'b1;
        end
      end
    for (int i = 0; i < m; i++) o[i] = v[i];
    return o;
  endfunction

  function automatic logic [PWT-1:0] rand_vec(input int top);
    logic [PWT-1:0] v;
    for (int j = 0; j < PWT; j += 32) v[j +: 32] = $urandom;
    for (int j = 0; j < PWT; j++) if (j >= top) v[j] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string req, input logic [OWT-1:0] act, input logic [OWT-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input int s, input logic [PWT-1:0] c);
    @(negedge clk);
    sel = 3'(s); p = c;
    #1;
    chk(s < 5 ? ftag[s] : "R6", r, ref_red(c, s));
    if (s < 5) chk("R7", r >> deg[s], '0);
  endtask

  initial begin
    logic [PWT-1:0] v;
    logic [OWT-1:0] hold;
    void'($urandom(32'd20240611));
    sel = '0; p = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    chk("R1", r, '0);  // zero in, zero out at start

    for (int s = 0; s < 5; s++) begin
      int m;
      m = deg[s];
      v = '0; v[m] = 1'b1;          apply(s, v);  // x^m
      v = '0; v[2*m-2] = 1'b1;      apply(s, v);  // top legal term
      apply(s, rand_vec(2*m-1) | ~rand_vec(0) & rand_vec(0)); // random
      v = '0; for (int j = 0; j < 2*m-1; j++) v[j] = 1'b1;
      apply(s, v);                                // all ones
      v = rand_vec(m);                            // already reduced
      @(negedge clk); sel = 3'(s); p = v; #1;
      chk("R8", r, v[OWT-1:0]);
      for (int k = 0; k < 30; k++) apply(s, rand_vec(2*m-1));
    end

    for (int s = 5; s < 8; s++)
      for (int k = 0; k < 4; k++) apply(s, rand_vec(PWT));

    // R9: change only the select, output follows without a clock edge
    v = rand_vec(325);
    @(negedge clk); sel = 3'd0; p = v; #1;
    hold = r;
    chk("R9", hold, ref_red(v, 0));
    #0.5 sel = 3'd4; #0.5;
    chk("R9", r, ref_red(v, 4));
    #0.5 sel = 3'd6; #0.5;
    chk("R9", r, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule